// File: doc/BRIEF.md
# Preloadable XNOR Shift-Register Countdown Timer

This block is a terminal-count timer built from one shift register with XNOR feedback. It needs far fewer lookup cells than a binary down-counter with a comparator. A parameter sets the width to 9 or 35 bits. Each width has a fixed pair of feedback taps that give a maximal-length cycle: 511 states for 9 bits and 2^35 − 1 states for 35 bits. The all-ones pattern is the one state outside the cycle. XNOR feedback can never leave it, so it must never be used as a preload.

While reset is held low, the register takes its starting pattern from the preload port on every clock. After reset is released, surrounding logic raises the step enable. The register then advances one position per clock until it holds all zeros. At that point the done flag rises, the register parks, and the surrounding logic drops the enable. Each legal preload maps to exactly one number of steps before zero is reached. The preload for a given delay is computed offline. The block never reloads itself.

An optional direction input selects the complementary register. It walks the same sequence backwards, one state per enabled clock, so a forward run can be retraced exactly. The block has no data stream: every pin is a plain control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `xnor_lfsr_timer`

## Requirements
- R1: While rst_n is low, each rising clock edge copies load_state into state. After release, state starts at the last value loaded.
- R2: A forward step (enable=1, reverse=0, done=0) shifts state up by one bit and writes ~(state[W-1] ^ state[T-1]) into bit 0. T is 5 when W is 9 and 33 when W is 35.
- R3: With enable low, state holds its value and reverse has no effect.
- R4: done is high in the same cycle that state is all zeros, and low otherwise, with no register delay.
- R5: While done is high, a forward-enabled clock leaves state at all zeros.
- R6: A reverse step (enable=1, reverse=1) shifts state down by one bit and writes ~(state[0] ^ state[T]) into bit W-1. It is permitted when state is zero.
- R7: One forward step followed by one reverse step restores the original state.
- R8: A preload that sits N forward steps from zero holds done low for N−1 enabled clocks and raises it on clock N. For W=9, a preload of 9'h001 needs 510 steps and passes through 511 distinct states, counting zero.
- R9: Starting from any legal preload, state never becomes all ones under any mix of forward and reverse steps.
- R10: The 35-bit configuration counts a bench-computed preload down to zero in the stated number of steps and follows the R2 rule at every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; load_state is captured while it is low |
| load_state | input | WIDTH | Starting pattern; must not be all ones |
| enable | input | 1 | Step enable from surrounding logic |
| reverse | input | 1 | 1 selects backward stepping (ignored when HAS_REVERSE is 0) |
| state | output | WIDTH | Current register contents |
| done | output | 1 | High while state is all zeros |

## Verification
On every cycle, the assertions check the shift direction of each step kind, holding when enable is low, parking at zero, the absence of the all-ones lockup pattern, and the capture of the preload at reset release. Only the bench's scenarios can show the following: that the feedback bit matches the polynomial; that a preload N steps from zero raises done on exactly the Nth clock; that the 9-bit cycle visits 511 distinct states; and that reverse stepping retraces a recorded forward trace state by state.

// File: rtl/xnor_lfsr_pkg.sv
package xnor_lfsr_pkg;

  // Second feedback tap (1-based bit number); the first tap is always the MSB.
  // Only widths 9 and 35 are supported with maximal-length cycles.
  function automatic int unsigned low_tap(input int unsigned width);
    case (width)
      9:       low_tap = 5;
      35:      low_tap = 33;
      default: low_tap = width - 1;
    endcase
  endfunction

  function automatic bit width_supported(input int unsigned width);
    width_supported = (width == 9) || (width == 35);
  endfunction

endpackage

// File: rtl/xnor_lfsr_fwd.sv
// Forward next-state: shift toward the MSB, feed XNOR of the taps into bit 0.
module xnor_lfsr_fwd #(
  parameter int unsigned W   = 9,
  parameter int unsigned TAP = 5
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;

  always_comb begin
    fb  = ~(cur[W-1] ^ cur[TAP-1]);
    nxt = {cur[W-2:0], fb};
  end
endmodule

// File: rtl/xnor_lfsr_rev.sv
// Reverse next-state: shift toward the LSB and rebuild the bit that the
// forward step dropped, using the taps as they sit after the forward shift.
module xnor_lfsr_rev #(
  parameter int unsigned W   = 9,
  parameter int unsigned TAP = 5
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic lost_msb;

  always_comb begin
    lost_msb = ~(cur[0] ^ cur[TAP]);
    prv      = {lost_msb, cur[W-1:1]};
  end
endmodule

// File: rtl/xnor_zero_detect.sv
// Terminal-state detector: a single wide NOR.
module xnor_zero_detect #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] vec,
  output logic         is_zero
);
  always_comb is_zero = ~|vec;
endmodule

// File: rtl/xnor_lfsr_timer.sv
module xnor_lfsr_timer
  import xnor_lfsr_pkg::*;
#(
  parameter int unsigned WIDTH       = 9,
  parameter bit          HAS_REVERSE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] load_state,
  input  logic             enable,
  input  logic             reverse,
  output logic [WIDTH-1:0] state,
  output logic             done
);
  localparam int unsigned TAP = low_tap(WIDTH);

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_fwd;
  logic [WIDTH-1:0] q_rev;
  logic             at_zero;
  logic             go_back;

  assign go_back = reverse & HAS_REVERSE;

  xnor_lfsr_fwd #(.W(WIDTH), .TAP(TAP)) u_fwd (
    .cur (q),
    .nxt (q_fwd)
  );

  generate
    if (HAS_REVERSE) begin : g_rev
      xnor_lfsr_rev #(.W(WIDTH), .TAP(TAP)) u_rev (
        .cur (q),
        .prv (q_rev)
      );
    end else begin : g_norev
      assign q_rev = q;
    end
  endgenerate

  xnor_zero_detect #(.W(WIDTH)) u_zero (
    .vec     (q),
    .is_zero (at_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= load_state;
    end else if (enable) begin
      if (go_back)       q <= q_rev;
      else if (!at_zero) q <= q_fwd;
    end
  end

  assign state = q;
  assign done  = at_zero;
endmodule

// File: rtl/xnor_lfsr_timer_chk.sv
module xnor_lfsr_timer_chk #(
  parameter int unsigned W   = 9,
  parameter int unsigned TAP = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] load_state,
  input logic         enable,
  input logic         reverse,
  input logic [W-1:0] state,
  input logic         done,
  input logic         go_back
);
  initial begin
    a_r10_width_ok: assert (xnor_lfsr_pkg::width_supported(W));
  end

  // R1: preload captured on the last reset edge.
  a_r1_preload: assert property (@(posedge clk)
    $rose(rst_n) |-> state == $past(load_state));

  // R2: forward step shifts up.
  a_r2_fwd_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !go_back && !done) |=> state[W-1:1] == $past(state[W-2:0]));

  // R3: idle keeps the state.
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(state));

  // R5: parked at zero under forward enable.
  a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !go_back && done) |=> done);

  // R6: reverse step shifts down.
  a_r6_rev_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && go_back) |=> state[W-2:0] == $past(state[W-1:1]));

  // R9: lockup pattern never reached.
  a_r9_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    state != {W{1'b1}});
endmodule

bind xnor_lfsr_timer xnor_lfsr_timer_chk #(.W(WIDTH), .TAP(TAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_state (load_state),
  .enable     (enable),
  .reverse    (reverse),
  .state      (state),
  .done       (done),
  .go_back    (go_back)
);

// File: tb/sim_xnor_lfsr_timer.sv
module sim_xnor_lfsr_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        reverse = 1'b0;
  logic [8:0]  load9 = 9'h0AB;
  logic [34:0] load35 = 35'h1;
  logic [8:0]  st9;
  logic [34:0] st35;
  logic        done9, done35;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [8:0] trace [0:510];
  logic       seen  [0:511];

  always #4 clk = ~clk;

  xnor_lfsr_timer #(.WIDTH(9)) u0 (
    .clk(clk), .rst_n(rst_n), .load_state(load9), .enable(enable),
    .reverse(reverse), .state(st9), .done(done9));

  xnor_lfsr_timer #(.WIDTH(35)) u1 (
    .clk(clk), .rst_n(rst_n), .load_state(load35), .enable(enable),
    .reverse(reverse), .state(st35), .done(done35));

  // Bench models taken from the requirement text (R2, R6).
  function automatic logic [8:0] fwd9(input logic [8:0] s);
    logic [8:0] r;
    for (int i = 8; i > 0; i--) r[i] = s[i-1];
    r[0] = ~(s[8] ^ s[4]);
    return r;
  endfunction

  function automatic logic [8:0] rev9(input logic [8:0] s);
    logic [8:0] r;
    for (int i = 0; i < 8; i++) r[i] = s[i+1];
    r[8] = ~(s[0] ^ s[5]);
    return r;
  endfunction

  function automatic logic [34:0] fwd35(input logic [34:0] s);
    logic [34:0] r;
    for (int i = 34; i > 0; i--) r[i] = s[i-1];
    r[0] = ~(s[34] ^ s[32]);
    return r;
  endfunction

  function automatic logic [34:0] rev35(input logic [34:0] s);
    logic [34:0] r;
    for (int i = 0; i < 34; i++) r[i] = s[i+1];
    r[34] = ~(s[0] ^ s[33]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [8:0] p9, input logic [34:0] p35);
    @(negedge clk);
    enable  = 1'b0;
    reverse = 1'b0;
    rst_n   = 1'b0;
    load9   = p9;
    load35  = p35;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    load9 = 9'h000;
    load35 = 35'h0;
  endtask

  task automatic t_reset();
    do_reset(9'h0AB, 35'h12345);
    check(st9 == 9'h0AB, "R1", st9, 9'h0AB);
    check(st35 == 35'h12345, "R1", st35, 35'h12345);
    check(done9 == 1'b0, "R4", done9, 0);
  endtask

  task automatic t_hold();
    logic [8:0] s0 = st9;
    reverse = 1'b1;
    repeat (5) @(negedge clk);
    check(st9 == s0, "R3", st9, s0);
    reverse = 1'b0;
  endtask

  task automatic t_step_back();
    logic [8:0] s0 = st9;
    enable = 1'b1;
    @(negedge clk);
    check(st9 == fwd9(s0), "R2", st9, fwd9(s0));
    reverse = 1'b1;
    @(negedge clk);
    check(st9 == s0, "R7", st9, s0);
    enable = 1'b0;
    reverse = 1'b0;
  endtask

  task automatic t_countdown(input int n);
    logic [8:0] p = 9'h000;
    bit early = 1'b0;
    for (int i = 0; i < n; i++) p = rev9(p);
    do_reset(p, 35'h1);
    enable = 1'b1;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (done9) early = 1'b1;
    end
    check(!early, "R8", early, 0);
    @(negedge clk);
    check(done9 && st9 == 9'h000, "R4", {done9, st9}, 10'h200);
    repeat (3) @(negedge clk);
    check(st9 == 9'h000 && done9, "R5", st9, 0);
    enable = 1'b0;
  endtask

  task automatic t_full_cycle();
    int steps = 0;
    int distinct = 0;
    bit lock = 1'b0;
    bit rule_ok = 1'b1;
    for (int i = 0; i < 512; i++) seen[i] = 1'b0;
    do_reset(9'h001, 35'h1);
    trace[0] = st9;
    seen[st9] = 1'b1;
    enable = 1'b1;
    while (!done9 && steps < 600) begin
      logic [8:0] prev = st9;
      @(negedge clk);
      steps++;
      if (st9 != fwd9(prev)) rule_ok = 1'b0;
      if (st9 == 9'h1FF) lock = 1'b1;
      if (steps <= 510) trace[steps] = st9;
      seen[st9] = 1'b1;
    end
    enable = 1'b0;
    for (int i = 0; i < 512; i++) if (seen[i]) distinct++;
    check(steps == 510, "R8", steps, 510);
    check(distinct == 511, "R8", distinct, 511);
    check(!lock, "R9", lock, 0);
    check(rule_ok, "R2", rule_ok, 1);
  endtask

  task automatic t_retrace();
    int bad = 0;
    enable = 1'b1;
    reverse = 1'b1;
    for (int k = 509; k >= 0; k--) begin
      @(negedge clk);
      if (st9 != trace[k]) bad++;
    end
    enable = 1'b0;
    reverse = 1'b0;
    check(bad == 0, "R6", bad, 0);
    check(st9 == 9'h001, "R6", st9, 9'h001);
  endtask

  task automatic t_wide(input int n);
    logic [34:0] p = 35'h0;
    bit rule_ok = 1'b1;
    bit early = 1'b0;
    for (int i = 0; i < n; i++) p = rev35(p);
    do_reset(9'h0AB, p);
    check(st35 == p, "R10", st35, p);
    enable = 1'b1;
    for (int i = 1; i <= n; i++) begin
      logic [34:0] prev = st35;
      @(negedge clk);
      if (st35 != fwd35(prev)) rule_ok = 1'b0;
      if (i < n && done35) early = 1'b1;
    end
    enable = 1'b0;
    check(rule_ok && !early, "R10", {rule_ok, early}, 2'b10);
    check(done35 && st35 == 35'h0, "R10", st35, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 50000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_hold();
    t_step_back();
    t_countdown(37);
    t_countdown(1);
    t_full_cycle();
    t_retrace();
    t_wide(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule